// File: doc/BRIEF.md
# Offset and Gain Trim Transition Detector

This block watches the stream of 14-bit offset-binary codes that a converter produces while its offset and gain trims are being adjusted. For the trim step in progress it watches two adjacent codes that straddle the transition of interest. Over a window of valid samples it counts how many samples land on each of the two codes, and how many land outside them on either side. At the end of each window it reports one of three verdicts. The input can sit below the transition or above it. Otherwise it is on the transition, which means the least significant bit toggles about evenly between the two codes.

A small sequencer controls the order of the trim steps. A step can start only once warmup is over. The gain step stays refused until the offset step has locked. Once a step is running, it repeats windows until a window locks. It then raises a per-step done flag and returns to idle. When the gain step locks, the block raises an overall completion flag.

Top module: `cal_flicker_detector`

## Requirements
- R1: In the offset step, the lower code is 0x2000 and the upper code is 0x2001. A sample below 0x2000 counts as below and a sample above 0x2001 counts as above.
- R2: In the gain step, the lower code is 0x3FFE and the upper code is 0x3FFF. A sample below 0x3FFE counts as below.
- R3: A start with `step_gain`=1 is ignored unless the offset step has locked since the last reset.
- R4: A start while `warm_done`=0 is ignored.
- R5: A window closes on its WIN-th valid sample. Cycles with `sample_vld`=0 neither count nor advance the window.
- R6: `locked` is set at window end when each of the two bracket codes was hit at least ceil(LO_PCT·WIN/100) times and at most floor(HI_PCT·WIN/100) times. When `locked` is set, both direction flags are 0.
- R7: For a window that does not lock, `dir_low` is set if (below + lower-code hits)·2 > WIN. `dir_high` is set if (above + upper-code hits)·2 > WIN. If neither holds, both flags are 0.
- R8: A window that does not lock starts a new window at once. A window that locks sets `step_done` and ends the step. A locked offset step enables the gain step. A locked gain step sets `cal_done`.
- R9: A synchronous reset clears all counters, the offset-locked state, `cal_done` and every output, and leaves the block idle.
- R10: A start command that arrives while a step is running is ignored.
- R11: The verdict outputs change on the clock edge that takes the window's last sample and hold until the next window end. An accepted start clears the verdict outputs and `step_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warm_done | input | 1 | Warmup period has elapsed |
| sample_vld | input | 1 | `sample` carries a new conversion result |
| sample | input | W | Offset-binary conversion result |
| step_go | input | 1 | Start-step command |
| step_gain | input | 1 | Step selection with the start: 0 offset, 1 gain |
| dir_low | output | 1 | Last window: input below the transition |
| dir_high | output | 1 | Last window: input above the transition |
| locked | output | 1 | Last window: on the transition |
| step_done | output | 1 | The most recent step has locked |
| cal_done | output | 1 | Gain step has locked |

## Verification
The bench builds the block with WIN=20, which gives a lock band of 8 to 12 hits per code. With a window that short, each boundary can be reached directly. A 7/13 split falls just outside the band and must report high. An 8/12 split must lock. A split of exactly half on each side must report neither direction. Windows spread over idle cycles show that only valid samples count. With several windows per step, the bench also covers automatic window restart, the refused gain start and starts issued during a run.

// File: rtl/cal_flicker_detector.sv
module cal_flicker_detector #(
  parameter int W      = 14,
  parameter int WIN    = 1024,
  parameter int LO_PCT = 40,
  parameter int HI_PCT = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         warm_done,
  input  logic         sample_vld,
  input  logic [W-1:0] sample,
  input  logic         step_go,
  input  logic         step_gain,
  output logic         dir_low,
  output logic         dir_high,
  output logic         locked,
  output logic         step_done,
  output logic         cal_done
);
  localparam int CW     = $clog2(WIN + 1);
  localparam int LO_MIN = (LO_PCT * WIN + 99) / 100;
  localparam int HI_MAX = (HI_PCT * WIN) / 100;
  localparam logic [W-1:0] OFS_LO  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] GAIN_LO = {{(W-1){1'b1}}, 1'b0};

  logic busy, gain_sel, off_ok;
  logic [CW-1:0] n_seen, n_lo, n_hi, n_below, n_above;

  wire [W-1:0] code_lo = gain_sel ? GAIN_LO : OFS_LO;
  wire [W-1:0] code_hi = code_lo + 1'b1;

  wire take   = busy & sample_vld;
  wire last   = take && (n_seen == CW'(WIN - 1));
  wire accept = step_go && !busy && warm_done && (!step_gain || off_ok);

  wire [CW-1:0] lo_nx    = n_lo    + CW'(sample == code_lo);
  wire [CW-1:0] hi_nx    = n_hi    + CW'(sample == code_hi);
  wire [CW-1:0] below_nx = n_below + CW'(sample <  code_lo);
  wire [CW-1:0] above_nx = n_above + CW'(sample >  code_hi);

  wire lo_in  = (lo_nx >= CW'(LO_MIN)) && (lo_nx <= CW'(HI_MAX));
  wire hi_in  = (hi_nx >= CW'(LO_MIN)) && (hi_nx <= CW'(HI_MAX));
  wire win_lock = lo_in && hi_in;

  wire [CW:0] lower_side = {1'b0, below_nx} + {1'b0, lo_nx};
  wire [CW:0] upper_side = {1'b0, above_nx} + {1'b0, hi_nx};
  wire low_v  = lower_side > (CW+1)'(WIN / 2);
  wire high_v = upper_side > (CW+1)'(WIN / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; gain_sel <= 1'b0; off_ok <= 1'b0;
      n_seen <= '0; n_lo <= '0; n_hi <= '0; n_below <= '0; n_above <= '0;
      dir_low <= 1'b0; dir_high <= 1'b0; locked <= 1'b0;
      step_done <= 1'b0; cal_done <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1; gain_sel <= step_gain;
      n_seen <= '0; n_lo <= '0; n_hi <= '0; n_below <= '0; n_above <= '0;
      dir_low <= 1'b0; dir_high <= 1'b0; locked <= 1'b0; step_done <= 1'b0;
    end else if (last) begin
      n_seen <= '0; n_lo <= '0; n_hi <= '0; n_below <= '0; n_above <= '0;
      locked   <= win_lock;
      dir_low  <= !win_lock && low_v;
      dir_high <= !win_lock && !low_v && high_v;
      if (win_lock) begin
        busy <= 1'b0;
        step_done <= 1'b1;
        if (gain_sel) cal_done <= 1'b1;
        else          off_ok   <= 1'b1;
      end
    end else if (take) begin
      n_seen <= n_seen + 1'b1;
      n_lo <= lo_nx; n_hi <= hi_nx; n_below <= below_nx; n_above <= above_nx;
    end
  end
endmodule

// File: rtl/cal_flicker_chk.sv
module cal_flicker_chk (
  input logic clk,
  input logic rst,
  input logic warm_done,
  input logic sample_vld,
  input logic step_go,
  input logic busy,
  input logic gain_sel,
  input logic off_ok,
  input logic dir_low,
  input logic dir_high,
  input logic locked,
  input logic step_done,
  input logic cal_done
);
  AST_GAIN_GATED: assert property (@(posedge clk) disable iff (rst) !off_ok |-> !(busy && gain_sel)); // R3
  AST_NO_COLD_START: assert property (@(posedge clk) disable iff (rst) (!busy && !warm_done) |=> !busy); // R4
  AST_LOCK_NO_DIR: assert property (@(posedge clk) disable iff (rst) locked |-> !(dir_low || dir_high)); // R6
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst) !(dir_low && dir_high)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) step_done |-> !busy); // R8
  AST_CAL_AFTER_OFS: assert property (@(posedge clk) disable iff (rst) cal_done |-> off_ok); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !(busy || off_ok || cal_done || step_done || locked || dir_low || dir_high)); // R9
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst) (!sample_vld && !step_go) |=> $stable({dir_low, dir_high, locked, step_done, cal_done})); // R11
endmodule

bind cal_flicker_detector cal_flicker_chk u_chk (
  .clk(clk), .rst(rst), .warm_done(warm_done), .sample_vld(sample_vld),
  .step_go(step_go), .busy(busy), .gain_sel(gain_sel), .off_ok(off_ok),
  .dir_low(dir_low), .dir_high(dir_high), .locked(locked),
  .step_done(step_done), .cal_done(cal_done)
);

// File: tb/sim_cal_flicker_detector.sv
module sim_cal_flicker_detector;
  localparam int W = 14;
  localparam int WIN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1, warm_done = 1'b0, sample_vld = 1'b0, step_go = 1'b0, step_gain = 1'b0;
  logic [W-1:0] sample = '0;
  logic dir_low, dir_high, locked, step_done, cal_done;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;

  always #4 clk = ~clk;

  cal_flicker_detector #(.W(W), .WIN(WIN), .LO_PCT(40), .HI_PCT(60)) u0 (
    .clk(clk), .rst(rst), .warm_done(warm_done), .sample_vld(sample_vld),
    .sample(sample), .step_go(step_go), .step_gain(step_gain),
    .dir_low(dir_low), .dir_high(dir_high), .locked(locked),
    .step_done(step_done), .cal_done(cal_done));

  // behavioural reference
  bit m_run, m_gain, m_ok, m_lo_f, m_hi_f, m_lk, m_sd, m_cd;
  int m_seen, m_a, m_b, m_bel, m_abv;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_run = 0; m_gain = 0; m_ok = 0; m_lo_f = 0; m_hi_f = 0; m_lk = 0; m_sd = 0; m_cd = 0;
      m_seen = 0; m_a = 0; m_b = 0; m_bel = 0; m_abv = 0;
    end else if (step_go && !m_run && warm_done && (!step_gain || m_ok)) begin
      m_run = 1; m_gain = step_gain; m_seen = 0; m_a = 0; m_b = 0; m_bel = 0; m_abv = 0;
      m_lo_f = 0; m_hi_f = 0; m_lk = 0; m_sd = 0;
    end else if (m_run && sample_vld) begin
      int lo_code;
      lo_code = m_gain ? 16'h3FFE : 16'h2000;
      if (int'(sample) == lo_code) m_a++;
      else if (int'(sample) == lo_code + 1) m_b++;
      else if (int'(sample) < lo_code) m_bel++;
      else m_abv++;
      m_seen++;
      if (m_seen == WIN) begin
        bit lk;
        lk = (m_a * 100 >= 40 * WIN) && (m_a * 100 <= 60 * WIN) &&
             (m_b * 100 >= 40 * WIN) && (m_b * 100 <= 60 * WIN);
        m_lk = lk;
        m_lo_f = !lk && (2 * (m_bel + m_a) > WIN);
        m_hi_f = !lk && (2 * (m_abv + m_b) > WIN);
        if (lk) begin
          m_run = 0; m_sd = 1;
          if (m_gain) m_cd = 1; else m_ok = 1;
        end
        m_seen = 0; m_a = 0; m_b = 0; m_bel = 0; m_abv = 0;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(dir_low, m_lo_f, "R7 dir_low vs model");
    chk(dir_high, m_hi_f, "R7 dir_high vs model");
    chk(locked, m_lk, "R6 locked vs model");
    chk(step_done, m_sd, "R8 step_done vs model");
    chk(cal_done, m_cd, "R8 cal_done vs model");
  end

  task automatic put(input logic [W-1:0] code, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample = code; sample_vld = 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample_vld = 0; step_go = 0;
    end
  endtask

  task automatic start(input logic g);
    @(negedge clk); sample_vld = 0; step_go = 1; step_gain = g;
    @(negedge clk); step_go = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);
    chk(locked, 0, "R9 reset locked"); chk(cal_done, 0, "R9 reset cal_done");
    chk(dir_low, 0, "R9 reset dir_low");
    // R4: cold start ignored
    start(0); put(14'h0000, WIN); idle(1);
    chk(dir_low, 0, "R4 start before warmup ignored");
    warm_done = 1;
    // R3: gain before offset ignored
    start(1); put(14'h3FFE, WIN/2); put(14'h3FFF, WIN/2); idle(1);
    chk(locked, 0, "R3 gain refused before offset lock");
    // offset step, window with gaps
    start(0);
    for (int i = 0; i < WIN - 1; i++) begin put(14'h0000, 1); idle(1); end
    chk(dir_low, 0, "R5 no verdict after WIN-1 valid samples");
    put(14'h1FFF, 1); idle(1);
    chk(dir_low, 1, "R5 verdict on WIN-th valid sample");
    chk(dir_low, 1, "R1 below 0x2000 counts low");
    put(14'h2002, WIN); idle(2);
    chk(dir_high, 1, "R1 above 0x2001 counts high");
    chk(dir_high, 1, "R11 verdict held while idle");
    put(14'h2000, 7); put(14'h2001, 13); idle(1);
    chk(locked, 0, "R6 7/13 outside band"); chk(dir_high, 1, "R7 7/13 reports high");
    put(14'h1000, 5); put(14'h2000, 5); put(14'h3000, 10); idle(1);
    chk(dir_low, 0, "R7 tie low flag"); chk(dir_high, 0, "R7 tie high flag");
    put(14'h2000, 8); put(14'h2001, 12); idle(1);
    chk(locked, 1, "R6 8/12 locks"); chk(step_done, 1, "R8 offset step done");
    chk(cal_done, 0, "R8 no cal_done after offset");
    // gain step
    start(1);
    chk(step_done, 0, "R11 accept clears step_done"); chk(locked, 0, "R11 accept clears locked");
    put(14'h2000, WIN); idle(1);
    chk(dir_low, 1, "R2 0x2000 below gain codes");
    start(0);
    put(14'h3FFE, 10); put(14'h3FFF, 10); idle(1);
    chk(locked, 1, "R10 start during run ignored, gain codes kept");
    chk(cal_done, 1, "R2 gain lock sets cal_done");
    // R9 reset
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; idle(1);
    chk(cal_done, 0, "R9 reset clears cal_done"); chk(locked, 0, "R9 reset clears locked");
    start(1); put(14'h3FFE, 10); put(14'h3FFF, 10); idle(1);
    chk(locked, 0, "R9 offset lock forgotten after reset");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule